// File: doc/BRIEF.md
# Strided Run-Length Expander

This block turns compact run descriptors into a stream of configuration values. Each descriptor holds a starting value, a step and a count of extra items. The block first emits the starting value, then one more value per cycle, each being the previous value plus the step, until the count is used up. A run of count N therefore takes N+1 output cycles. Descriptors arrive on a 24-bit input with a valid/ready handshake. Values leave on a 16-bit output qualified by a valid strobe.

The layout of a descriptor is chosen by a 4-bit format code, sampled once each time the enable input goes high. Address formats carry a 16-bit starting value, and the low byte of the descriptor is split between count and step, in a proportion the format picks. Byte formats carry an 8-bit value that is repeated with no step; they come in 12-, 16- and 24-bit sizes. A separate output shows how many values are still pending after the current one. Outside logic can compare this figure against other streams.

Top module: `stride_rle_expander`

## Requirements
- R1: A descriptor with start S, step T and count N produces exactly N+1 output values S, S+T, S+2T, ... in consecutive cycles, after which `out_valid` falls unless a new descriptor was accepted.
- R2: The first value of a run appears on `out_value` with `out_valid` high in the cycle after the handshake (`cw_valid && cw_ready` at a rising clock edge).
- R3: `cw_ready` is low while more than one value of the current run remains, and high in the cycle that shows the run's last value; a descriptor accepted then starts its run the very next cycle, with no idle cycle between runs.
- R4: For address format codes 0 to 6, the number of count bits is K = code+1. The start value is `cw_data[23:8]`, the count is the upper K bits of `cw_data[7:0]`, and the step is the lower 8-K bits. Codes 7 and 11 to 15 behave as code 4 (5 count bits, 3 step bits).
- R5: Byte format codes 8, 9 and 10 take a zero step, and the output is zero-extended to 16 bits. Code 8 uses value `cw_data[11:4]` with count `cw_data[3:0]`. Code 9 uses value `cw_data[15:8]` with count `cw_data[7:0]`. Code 10 uses value `cw_data[23:16]` with count `cw_data[15:0]`. All unused upper bits are ignored.
- R6: Address arithmetic wraps modulo 2^16, and the step is unsigned.
- R7: `mode_cfg` is captured only at the clock edge where `en` is high and was low in the previous cycle. In that first enabled cycle `cw_ready` stays low. Changes of `mode_cfg` while `en` stays high do not affect later descriptors.
- R8: `remaining` equals the number of values of the current run still to come after the one on `out_value`, and is 0 when `out_valid` is low.
- R9: While `en` is low, `cw_ready` is low and offered descriptors produce no output. A run already in progress finishes even if `en` falls.
- R10: While `rst_n` is low (asynchronous, active low), `out_valid`, `cw_ready` and `remaining` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Decompression enable; its rising edge captures the format code |
| mode_cfg | input | 4 | Format code (R4, R5) |
| cw_valid | input | 1 | Descriptor offered |
| cw_ready | output | 1 | Descriptor can be taken this cycle |
| cw_data | input | 24 | Descriptor bits |
| out_valid | output | 1 | Output value is valid |
| out_value | output | 16 | Expanded value |
| remaining | output | 16 | Values still to come in the current run |

## Verification
The hardest case to reach from the ports is the hand-over between runs. A new descriptor must be taken in exactly the cycle that shows the previous run's last value. That same cycle must not be lost or doubled. To get there, the stimulus holds a second descriptor on the input while the first run is still expanding, so that the handshake completes on its own at the boundary. Each value on both sides is then checked cycle by cycle. Two other paths need care: the wrap past 0xFFFF and the longest byte run. They are reached by table entries chosen to cross them, and the format capture is exercised by changing `mode_cfg` while `en` stays high.

// File: rtl/stride_rle_pkg.sv
package stride_rle_pkg;

  localparam int VAL_W   = 16;
  localparam int CW_W    = 24;
  localparam int CNT_W   = 16;
  localparam int MODE_W  = 4;
  localparam int SPLIT_W = 8;
  localparam int BYTE_W  = 8;

  localparam logic [MODE_W-1:0] FMT_ADDR_LAST = 4'd6;
  localparam logic [MODE_W-1:0] FMT_BYTE12    = 4'd8;
  localparam logic [MODE_W-1:0] FMT_BYTE16    = 4'd9;
  localparam logic [MODE_W-1:0] FMT_BYTE24    = 4'd10;
  localparam logic [MODE_W-1:0] FMT_DEFAULT   = 4'd4;

  typedef struct packed {
    logic [VAL_W-1:0] start;
    logic [VAL_W-1:0] step;
    logic [CNT_W-1:0] count;
  } run_desc_t;

  // Number of step bits in an address format (8 minus count bits).
  function automatic int unsigned step_bits(input logic [MODE_W-1:0] fmt);
    if (fmt <= FMT_ADDR_LAST) return 32'd7 - 32'(fmt);
    else                      return 32'd3;
  endfunction

  // Next value of a run, wrapping modulo 2^VAL_W.
  function automatic logic [VAL_W-1:0] advance(input logic [VAL_W-1:0] v,
                                               input logic [VAL_W-1:0] s);
    return v + s;
  endfunction

  function automatic run_desc_t unpack_cw(input logic [CW_W-1:0] cw,
                                          input logic [MODE_W-1:0] fmt);
    run_desc_t          d;
    logic [SPLIT_W-1:0] low;
    logic [SPLIT_W-1:0] smask;
    int unsigned        sw;
    d = '0;
    case (fmt)
      FMT_BYTE12: begin
        d.start = {{(VAL_W-BYTE_W){1'b0}}, cw[11:4]};
        d.count = {{(CNT_W-4){1'b0}}, cw[3:0]};
      end
      FMT_BYTE16: begin
        d.start = {{(VAL_W-BYTE_W){1'b0}}, cw[15:8]};
        d.count = {{(CNT_W-8){1'b0}}, cw[7:0]};
      end
      FMT_BYTE24: begin
        d.start = {{(VAL_W-BYTE_W){1'b0}}, cw[23:16]};
        d.count = cw[15:0];
      end
      default: begin
        sw      = step_bits(fmt);
        low     = cw[SPLIT_W-1:0];
        smask   = 8'hFF >> (32'd8 - sw);
        d.start = cw[CW_W-1:SPLIT_W];
        d.step  = {{(VAL_W-SPLIT_W){1'b0}}, low & smask};
        d.count = {{(CNT_W-SPLIT_W){1'b0}}, low >> sw};
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/stride_rle_unpack.sv
module stride_rle_unpack
  import stride_rle_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  input  logic [MODE_W-1:0] fmt,
  output run_desc_t         desc
);

  always_comb desc = unpack_cw(cw, fmt);

endmodule

// File: rtl/stride_rle_engine.sv
module stride_rle_engine
  import stride_rle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  run_desc_t        desc,
  output logic             busy,
  output logic             last,
  output logic [VAL_W-1:0] value,
  output logic [CNT_W-1:0] left
);

  logic [CNT_W-1:0] cnt_q;
  logic [VAL_W-1:0] step_q;
  logic             step_evt;

  assign step_evt = busy && (cnt_q != '0);
  assign last     = busy && (cnt_q == '0);
  assign left     = busy ? cnt_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      value  <= '0;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      value  <= desc.start;
      cnt_q  <= desc.count;
      step_q <= desc.step;
    end else if (step_evt) begin
      value  <= advance(value, step_q);
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      busy   <= 1'b0;
    end
  end

  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && (value == $past(desc.start)));

  p_step_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load) |=> busy && (value == 16'($past(value) + $past(step_q))));

  p_left_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load) |=> (left == $past(left) - 1'b1));

  p_run_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !busy && (left == '0));

endmodule

// File: rtl/stride_rle_expander.sv
module stride_rle_expander
  import stride_rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic              cw_valid,
  output logic              cw_ready,
  input  logic [CW_W-1:0]   cw_data,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_value,
  output logic [CNT_W-1:0]  remaining
);

  logic [MODE_W-1:0] fmt_q;
  logic              en_q;
  logic              en_rise;
  logic              accept;
  logic              busy;
  logic              last;
  run_desc_t         desc;

  assign en_rise  = en && !en_q;
  assign cw_ready = en && en_q && (!busy || last);
  assign accept   = cw_valid && cw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fmt_q <= FMT_DEFAULT;
    end else begin
      en_q <= en;
      if (en_rise) fmt_q <= mode_cfg;
    end
  end

  stride_rle_unpack u_unpack (
    .cw   (cw_data),
    .fmt  (fmt_q),
    .desc (desc)
  );

  stride_rle_engine u_engine (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .desc  (desc),
    .busy  (busy),
    .last  (last),
    .value (out_value),
    .left  (remaining)
  );

  assign out_valid = busy;

  p_ready_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cw_ready);

  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_valid) |=> out_valid);

  p_hold_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && remaining != '0) |-> !cw_ready);

  p_first_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !cw_ready);

endmodule

// File: tb/stride_rle_expander_tb.sv
module stride_rle_expander_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [3:0]  mode;
    logic [23:0] cw;
    logic [15:0] start;
    logic [15:0] step;
    logic [15:0] count;
  } vec_t;

  // R4 address splits, R5 byte formats, R6 wrap
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  24'h006423, 16'd100,    16'd3,    16'd4},   // R4 K=5
    '{4'd0,  24'h1000FF, 16'h1000,   16'h007F, 16'd1},   // R4 K=1
    '{4'd6,  24'hFFFE07, 16'hFFFE,   16'd1,    16'd3},   // R6 wrap, K=7
    '{4'd3,  24'h020005, 16'h0200,   16'd5,    16'd0},   // R4 single value
    '{4'd8,  24'hFFFA52, 16'h00A5,   16'd0,    16'd2},   // R5 12-bit
    '{4'd9,  24'hEE3C05, 16'h003C,   16'd0,    16'd5},   // R5 16-bit
    '{4'd10, 24'h810010, 16'h0081,   16'd0,    16'd16},  // R5 24-bit
    '{4'd7,  24'h001017, 16'h0010,   16'd7,    16'd2},   // R4 unknown code
    '{4'd5,  24'h4000FF, 16'h4000,   16'd3,    16'd63}   // R4 K=6, long run
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  mode_cfg;
  logic        cw_valid;
  logic        cw_ready;
  logic [23:0] cw_data;
  logic        out_valid;
  logic [15:0] out_value;
  logic [15:0] remaining;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  stride_rle_expander u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode_cfg  (mode_cfg),
    .cw_valid  (cw_valid),
    .cw_ready  (cw_ready),
    .cw_data   (cw_data),
    .out_valid (out_valid),
    .out_value (out_value),
    .remaining (remaining)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    en = 1'b0;
    mode_cfg = m;
    @(negedge clk);
    en = 1'b1;
    #1 check("R7 ready low in first enabled cycle", 32'(cw_ready), 32'd0);
    @(negedge clk);
    check("R7 ready after enable", 32'(cw_ready), 32'd1);
  endtask

  // Offers one descriptor (idle block, ready high) and checks the whole run.
  task automatic send_check(input logic [23:0] cw, input logic [15:0] s,
                            input logic [15:0] t, input logic [15:0] n);
    cw_valid = 1'b1;
    cw_data  = cw;
    @(negedge clk);
    cw_valid = 1'b0;
    for (int i = 0; i <= int'(n); i++) begin
      check("R2 out_valid during run", 32'(out_valid), 32'd1);
      check("R1 value", 32'(out_value), 32'(16'(s + 16'(i) * t)));
      check("R8 remaining", 32'(remaining), 32'(n) - 32'(i));
      @(negedge clk);
    end
    check("R1 run ends", 32'(out_valid), 32'd0);
    check("R8 remaining idle", 32'(remaining), 32'd0);
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; mode_cfg = 4'd4; cw_valid = 1'b0; cw_data = '0;
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", 32'(out_valid), 32'd0);
    check("R10 cw_ready in reset", 32'(cw_ready), 32'd0);
    check("R10 remaining in reset", 32'(remaining), 32'd0);
    rst_n = 1'b1;

    // Table walk: R1 R2 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      set_mode(VEC[v].mode);
      send_check(VEC[v].cw, VEC[v].start, VEC[v].step, VEC[v].count);
    end

    // R3: back-to-back runs with the second descriptor held early
    set_mode(4'd4);
    cw_valid = 1'b1;
    cw_data  = 24'h010011;          // 0x0100, step 1, count 2
    @(negedge clk);
    cw_data  = 24'h02000A;          // 0x0200, step 2, count 1
    check("R3 first value", 32'(out_value), 32'h0100);
    check("R3 ready low mid-run", 32'(cw_ready), 32'd0);
    @(negedge clk);
    check("R3 second value", 32'(out_value), 32'h0101);
    @(negedge clk);
    check("R3 last value", 32'(out_value), 32'h0102);
    check("R3 ready on last value", 32'(cw_ready), 32'd1);
    @(negedge clk);
    cw_valid = 1'b0;
    check("R3 no gap valid", 32'(out_valid), 32'd1);
    check("R3 next run start", 32'(out_value), 32'h0200);
    check("R3 next run remaining", 32'(remaining), 32'd1);
    @(negedge clk);
    check("R3 next run step", 32'(out_value), 32'h0202);
    @(negedge clk);
    check("R3 idle after runs", 32'(out_valid), 32'd0);

    // R7: format change while enabled has no effect
    set_mode(4'd4);
    @(negedge clk);
    mode_cfg = 4'd0;
    @(negedge clk);
    send_check(24'h006423, 16'd100, 16'd3, 16'd4);   // R7 still K=5

    // R9: disabled block ignores descriptors
    @(negedge clk);
    en = 1'b0;
    cw_valid = 1'b1;
    cw_data  = 24'h006423;
    for (int k = 0; k < 3; k++) begin
      #1 check("R9 ready low when disabled", 32'(cw_ready), 32'd0);
      @(negedge clk);
      check("R9 no output when disabled", 32'(out_valid), 32'd0);
    end
    cw_valid = 1'b0;

    // R9: run started before en falls still completes
    set_mode(4'd4);
    cw_valid = 1'b1;
    cw_data  = 24'h010011;
    @(negedge clk);
    cw_valid = 1'b0;
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R9 run continues valid", 32'(out_valid), 32'd1);
      check("R9 run continues value", 32'(out_value), 32'h0100 + 32'(i));
      @(negedge clk);
    end
    check("R9 run finished", 32'(out_valid), 32'd0);

    // R10: reset in the middle of a long byte run
    set_mode(4'd10);
    cw_valid = 1'b1;
    cw_data  = 24'h810010;
    @(negedge clk);
    cw_valid = 1'b0;
    @(negedge clk);
    check("R10 run active before reset", 32'(out_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    check("R10 out_valid cleared", 32'(out_valid), 32'd0);
    check("R10 remaining cleared", 32'(remaining), 32'd0);
    check("R10 ready cleared", 32'(cw_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 stays idle after reset", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule